// File: doc/BRIEF.md
# Alternating-Compare Toggle PWM Timer

This timer channel produces a pulse-width-modulated output by toggling an internal output flag each time its up-counter matches the active compare value. The active compare alternates between two registers: the low-phase compare sets how long the flag stays low and the high-phase compare sets how long it stays high. On each match the counter returns to zero, so a full period lasts (low compare + 1) + (high compare + 1) enabled clocks.

Software sets up the channel through a small write port. It can write either compare directly, or it can use two preload registers to change the duty without a glitch. When preloading is enabled, each compare register is refreshed from its preload at the match of the other compare. The high-phase compare reloads when the low phase ends, and the low-phase compare reloads when the high phase ends. A clock-enable input advances the counter. Control bits gate the flag onto the pin and can invert it.

Top module: `toggle_pwm_timer`

## Requirements
- R1: After reset the flag is low, the low-phase compare is active and the counter is 0. All compares, preloads and control bits are 0, so `pwm_out` is 0.
- R2: The flag stays low for (low compare + 1) enabled clocks. The low compare is written at address 0.
- R3: At the end of the low phase the flag goes high and stays high for (high compare + 1) enabled clocks. The high compare is written at address 1. The two phases then repeat in alternation.
- R4: A compare value of 0 gives a phase of exactly one enabled clock, so no phase is ever zero length.
- R5: Control bit 1 (address 4) inverts the pin relative to the flag.
- R6: When control bit 0 (address 4) is 0, `pwm_out` is held at 0 whatever the flag does.
- R7: When control bit 2 (address 4) is set, the high compare is loaded from the high preload (address 3) at the low-phase match. The low compare is loaded from the low preload (address 2) at the high-phase match. A preload write does not change the phase that is in progress.
- R8: When control bit 2 is 0, the preload registers have no effect on the output.
- R9: A direct write to a compare register takes effect from the next clock.
- R10: While `cnt_en` is 0, the counter and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address: 0 low compare, 1 high compare, 2 low preload, 3 high preload, 4 control |
| wr_data | input | CW (16) | Write data; control uses bit0 output enable, bit1 invert, bit2 preload enable |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench measures the lengths of consecutive output runs for several compare pairs. Unequal values (3/5) tell the low phase from the high phase and expose an off-by-one in either phase. Zero values check the one-clock minimum. A preload set that differs from the live compares (7/1 against 3/5) yields the sequence 4,2,8,2,8. That sequence separates a reload on the correct opposite event from an immediate load, a same-phase load or no load. The same set with preloading off must leave 4,6 unchanged. A pattern that pauses the clock enable and writes a compare during the pause tells hold from free running, and shows that a direct write is immediate.

// File: rtl/toggle_pwm_timer.sv
module toggle_pwm_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out
);

  localparam logic [AW-1:0] A_CMP_LO = AW'(0);
  localparam logic [AW-1:0] A_CMP_HI = AW'(1);
  localparam logic [AW-1:0] A_PRE_LO = AW'(2);
  localparam logic [AW-1:0] A_PRE_HI = AW'(3);
  localparam logic [AW-1:0] A_CTRL   = AW'(4);

  logic [CW-1:0] cnt, cmp_lo, cmp_hi, pre_lo, pre_hi;
  logic          flag, hi_sel;
  logic          oe, inv, pre_en;

  wire [CW-1:0] cur_cmp = hi_sel ? cmp_hi : cmp_lo;
  wire          match   = cnt_en && (cnt == cur_cmp);
  wire          wr_clo  = wr_en && (wr_addr == A_CMP_LO);
  wire          wr_chi  = wr_en && (wr_addr == A_CMP_HI);

  assign pwm_out = oe & (flag ^ inv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      flag   <= 1'b0;
      hi_sel <= 1'b0;
    end else if (match) begin
      cnt    <= '0;
      flag   <= ~flag;
      hi_sel <= ~hi_sel;
    end else if (cnt_en) begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
      pre_lo <= '0;
      pre_hi <= '0;
      oe     <= 1'b0;
      inv    <= 1'b0;
      pre_en <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_PRE_LO) pre_lo <= wr_data;
      if (wr_en && wr_addr == A_PRE_HI) pre_hi <= wr_data;
      if (wr_en && wr_addr == A_CTRL) begin
        oe     <= wr_data[0];
        inv    <= wr_data[1];
        pre_en <= wr_data[2];
      end
      if (wr_clo)                              cmp_lo <= wr_data;
      else if (match && hi_sel && pre_en)      cmp_lo <= pre_lo;
      if (wr_chi)                              cmp_hi <= wr_data;
      else if (match && !hi_sel && pre_en)     cmp_hi <= pre_hi;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt) && $stable(flag));

  p_toggle_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == cur_cmp) |=> (flag != $past(flag)) && (cnt == '0));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt != cur_cmp) |=> $stable(flag) && (cnt == $past(cnt) + 1'b1));

  p_reload_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pre_en && !hi_sel && cnt == cmp_lo && !wr_chi) |=> cmp_hi == $past(pre_hi));

  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && !wr_en) |=> $stable(cmp_lo) && $stable(cmp_hi));

endmodule

// File: tb/toggle_pwm_timer_bench.sv
module toggle_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit smp [0:127];

  always #2 clk = ~clk;

  toggle_pwm_timer u_toggle_pwm_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic collect(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp[i] = pwm_out;
      cnt_en = 1'b1;
    end
    cnt_en = 1'b0;
  endtask

  function automatic int run_len(int k);
    int idx = 0;
    int r = 0;
    int len = 0;
    for (int i = 0; i < 128; i++) begin
      if (i > 0 && smp[i] != smp[i-1]) r++;
      if (r == k) len++;
      if (r > k) break;
      idx = i;
    end
    return len;
  endfunction

  task automatic chk_runs(string req, int lvl, int e0, int e1, int e2, int e3, int e4);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    chk(req, int'(smp[0]), lvl);
    for (int k = 0; k < 5; k++)
      if (e[k] > 0) chk(req, run_len(k), e[k]);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", int'(pwm_out), 0);
    wr(3'd4, 16'h0001);
    @(negedge clk);
    chk("R1", int'(pwm_out), 0);
    wr(3'd4, 16'h0003);
    @(negedge clk);
    chk("R5", int'(pwm_out), 1);
  endtask

  task automatic t_basic();
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd5); wr(3'd4, 16'h0001);
    collect(40);
    chk_runs("R2_R3", 0, 4, 6, 4, 6, 4);
  endtask

  task automatic t_zero();
    do_reset();
    wr(3'd4, 16'h0001);
    collect(20);
    chk_runs("R4", 0, 1, 1, 1, 1, 1);
    do_reset();
    wr(3'd1, 16'd2); wr(3'd4, 16'h0001);
    collect(20);
    chk_runs("R4", 0, 1, 3, 1, 3, 1);
  endtask

  task automatic t_polarity();
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd5); wr(3'd4, 16'h0003);
    collect(40);
    chk_runs("R5", 1, 4, 6, 4, 6, 0);
  endtask

  task automatic t_outen();
    int ones = 0;
    do_reset();
    wr(3'd0, 16'd2); wr(3'd1, 16'd1); wr(3'd4, 16'h0002);
    collect(40);
    for (int i = 0; i < 40; i++) ones += int'(smp[i]);
    chk("R6", ones, 0);
  endtask

  task automatic t_preload();
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd5);
    wr(3'd2, 16'd7); wr(3'd3, 16'd1); wr(3'd4, 16'h0005);
    collect(60);
    chk_runs("R7", 0, 4, 2, 8, 2, 8);
  endtask

  task automatic t_nopreload();
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd5);
    wr(3'd2, 16'd7); wr(3'd3, 16'd1); wr(3'd4, 16'h0001);
    collect(60);
    chk_runs("R8", 0, 4, 6, 4, 6, 4);
  endtask

  task automatic t_hold_direct();
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd3); wr(3'd4, 16'h0001);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      smp[i] = pwm_out;
      cnt_en = !(i >= 2 && i < 12);
      if (i == 5) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd6; end
      if (i == 6) wr_en = 1'b0;
    end
    cnt_en = 1'b0;
    chk("R10", run_len(0), 17);
    chk("R9", run_len(1), 4);
    chk("R9", run_len(2), 7);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero();
    t_polarity();
    t_outen();
    t_preload();
    t_nopreload();
    t_hold_direct();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule